// File: doc/BRIEF.md
# Capacitance-to-Time Slope Control and Interval Logic

This block is the digital side of a constant-current capacitance meter. An integrator charges the unknown capacitor with a fixed current whose sign is chosen by this logic, so its output is a triangle wave. Two limit comparators report when the ramp reaches its top or bottom. The block then flips the integrator polarity through a set/reset state register that can never be driven both ways at once.

A single precision zero-crossing comparator measures the time interval. Its reference is swapped between the positive and negative level by a second race-free state register. Two early comparators drive that register, and they trip well before the ramp nears zero, so the reference has settled in time. The comparator decision is registered and gated with the current polarity. This gives one interval pulse for rising ramps, one for falling ramps, and their OR.

Two output lines drive an isolated link. They carry either the two slope pulses or the combined pulse and its complement. A pushbutton, synchronised and debounced, steps a one-hot range selector through three ranges. An external control input can take over the range selection.

Top module: `ctc_slope_logic`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, integ_up_o is 1, ref_sel_o is 0, rise_o, fall_o and both_o are 0, and range_o is 3'b001.
- R2: If lim_lo_i alone is high at a clock edge, integ_up_o is 1 after that edge. If lim_hi_i alone is high, integ_up_o is 0 after that edge. If both are high, integ_up_o keeps its value.
- R3: If early_rise_i alone is high at a clock edge, ref_sel_o is 1 after that edge. If early_fall_i alone is high, ref_sel_o is 0. If both are high, ref_sel_o keeps its value.
- R4: rise_o equals the value zero_i had at the previous clock edge, ANDed with integ_up_o. It is 0 whenever integ_up_o is 0.
- R5: fall_o equals the inverse of the value zero_i had at the previous clock edge, ANDed with the inverse of integ_up_o. It is 0 whenever integ_up_o is 1.
- R6: both_o equals rise_o OR fall_o.
- R7: With link_mode_i = 0, link_o[0] = rise_o and link_o[1] = fall_o. With link_mode_i = 1, link_o[0] = both_o and link_o[1] = NOT both_o.
- R8: range_o is always one-hot. Bit 0 is the first range. Each debounced press, counted when the debounced button level rises, moves the set bit one place up, and the move from bit 2 wraps to bit 0.
- R9: btn_i passes through a two-flop synchroniser. A change of level counts only after it has been seen unchanged for DB_CYCLES consecutive cycles. Shorter pulses do not advance range_o.
- R10: While ext_en_i is high, range_o is the one-hot decode of ext_range_i (0, 1 or 2), and index 3 maps to 3'b001. The internal range is kept and shows again once ext_en_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lim_hi_i | input | 1 | Upper-limit comparator, ramp at top |
| lim_lo_i | input | 1 | Lower-limit comparator, ramp at bottom |
| early_rise_i | input | 1 | Early comparator for the rising ramp |
| early_fall_i | input | 1 | Early comparator for the falling ramp |
| zero_i | input | 1 | Main zero-crossing comparator |
| btn_i | input | 1 | Range pushbutton, asynchronous |
| ext_en_i | input | 1 | External range control enable |
| ext_range_i | input | 2 | External range index |
| link_mode_i | input | 1 | Link mux: 0 slope pair, 1 combined pair |
| integ_up_o | output | 1 | Integrator polarity, 1 = rising ramp |
| ref_sel_o | output | 1 | Main comparator reference select |
| rise_o | output | 1 | Rising-slope interval pulse |
| fall_o | output | 1 | Falling-slope interval pulse |
| both_o | output | 1 | Combined interval pulse |
| link_o | output | 2 | Isolated link lines |
| range_o | output | 3 | One-hot range select |

## Verification
Assertions check several properties on every cycle. Each state register obeys set, clear and hold-on-conflict. An active slope pulse always matches the comparator value registered one edge earlier. The range stays one-hot, and it never moves without a debounced press. Only the bench scenarios show the rest: that a short button glitch is rejected while a long press wraps the range through all three states, that the link lines follow the chosen mode, and that the external override hands control back to the kept internal range.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic {
    LINK_SLOPES = 1'b0,
    LINK_COMBO  = 1'b1
  } link_mode_e;
endpackage

// File: rtl/sr_hold_latch.sv
module sr_hold_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= RST_VAL;
    else if (set_i && !clr_i)   q_q <= 1'b1;
    else if (clr_i && !set_i)   q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R2 on the polarity instance, R3 on the reference instance
  assert_conflict_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> (q_o == $past(q_o)));
  assert_set_wins_alone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);
  assert_clr_wins_alone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/slope_gate.sv
module slope_gate #(
  parameter logic MATCH_UP = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_i,
  input  logic up_i,
  output logic pulse_o
);
  logic zc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zc_q <= 1'b0;
    else         zc_q <= zero_i;
  end

  // falling path uses the complementary comparator sense
  assign pulse_o = ((MATCH_UP ? zc_q : !zc_q)) && (up_i == MATCH_UP);

  // R4 for the rising instance, R5 for the falling one
  assert_slope_follows_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ($past(zero_i) == MATCH_UP));
endmodule

// File: rtl/range_select.sv
module range_select #(
  parameter int N_RANGES  = 3,
  parameter int DB_CYCLES = 16,
  localparam int IDX_W    = (N_RANGES > 1) ? $clog2(N_RANGES) : 1,
  localparam int CNT_W    = $clog2(DB_CYCLES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                btn_i,
  input  logic                ext_en_i,
  input  logic [IDX_W-1:0]    ext_range_i,
  output logic [N_RANGES-1:0] range_o
);
  logic [1:0]          sync_q;
  logic                lvl_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                press;
  logic [N_RANGES-1:0] range_q;
  logic [N_RANGES-1:0] ext_dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], btn_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (sync_q[1] == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(DB_CYCLES - 1)) begin
      lvl_q <= sync_q[1];
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign press = (sync_q[1] != lvl_q) && (cnt_q == CNT_W'(DB_CYCLES - 1)) && sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    range_q <= N_RANGES'(1);
    else if (press) range_q <= {range_q[N_RANGES-2:0], range_q[N_RANGES-1]};
  end

  always_comb begin
    ext_dec = '0;
    for (int i = 0; i < N_RANGES; i++)
      if (ext_range_i == IDX_W'(i)) ext_dec[i] = 1'b1;
    if (ext_dec == '0) ext_dec[0] = 1'b1;
  end

  assign range_o = ext_en_i ? ext_dec : range_q;

  assert_range_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(range_q) == 1);
  assert_no_step_without_press_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press |=> $stable(range_q));
  assert_out_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(range_o) == 1);
endmodule

// File: rtl/ctc_slope_logic.sv
module ctc_slope_logic
  import ctc_pkg::*;
#(
  parameter int N_RANGES  = 3,
  parameter int DB_CYCLES = 16,
  localparam int IDX_W    = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lim_hi_i,
  input  logic                lim_lo_i,
  input  logic                early_rise_i,
  input  logic                early_fall_i,
  input  logic                zero_i,
  input  logic                btn_i,
  input  logic                ext_en_i,
  input  logic [IDX_W-1:0]    ext_range_i,
  input  logic                link_mode_i,
  output logic                integ_up_o,
  output logic                ref_sel_o,
  output logic                rise_o,
  output logic                fall_o,
  output logic                both_o,
  output logic [1:0]          link_o,
  output logic [N_RANGES-1:0] range_o
);
  logic up;
  logic [1:0] pulses;

  sr_hold_latch #(.RST_VAL(1'b1)) u_pol (
    .clk_i, .rst_ni, .set_i(lim_lo_i), .clr_i(lim_hi_i), .q_o(up)
  );

  sr_hold_latch #(.RST_VAL(1'b0)) u_ref (
    .clk_i, .rst_ni, .set_i(early_rise_i), .clr_i(early_fall_i), .q_o(ref_sel_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_slope
    slope_gate #(.MATCH_UP(g == 0)) u_gate (
      .clk_i, .rst_ni, .zero_i, .up_i(up), .pulse_o(pulses[g])
    );
  end

  assign integ_up_o = up;
  assign rise_o     = pulses[0];
  assign fall_o     = pulses[1];
  assign both_o     = |pulses;

  always_comb begin
    if (link_mode_e'(link_mode_i) == LINK_COMBO) link_o = {!both_o, both_o};
    else                                          link_o = {fall_o, rise_o};
  end

  range_select #(.N_RANGES(N_RANGES), .DB_CYCLES(DB_CYCLES)) u_range (
    .clk_i, .rst_ni, .btn_i, .ext_en_i, .ext_range_i, .range_o
  );

  assert_slopes_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  assert_link_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_mode_i |-> (link_o[0] != link_o[1]));
endmodule

// File: tb/ctc_slope_logic_tb.sv
module ctc_slope_logic_tb;
  localparam int DB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lim_hi = 0, lim_lo = 0, e_rise = 0, e_fall = 0, zero = 0;
  logic btn = 0, ext_en = 0, mode = 0;
  logic [1:0] ext_rng = 0;
  logic up, rsel, rise, fall, both;
  logic [1:0] link;
  logic [2:0] rng;
  int errors = 0, checks = 0;
  int exp_idx = 0;

  always #2.5 clk = ~clk;

  ctc_slope_logic #(.N_RANGES(3), .DB_CYCLES(DB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lim_hi_i(lim_hi), .lim_lo_i(lim_lo),
    .early_rise_i(e_rise), .early_fall_i(e_fall), .zero_i(zero),
    .btn_i(btn), .ext_en_i(ext_en), .ext_range_i(ext_rng), .link_mode_i(mode),
    .integ_up_o(up), .ref_sel_o(rsel), .rise_o(rise), .fall_o(fall),
    .both_o(both), .link_o(link), .range_o(rng)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 up", up, 1); chk("R1 ref", rsel, 0);
    chk("R1 pulses", {rise, fall, both}, 0); chk("R1 range", rng, 3'b001);
    @(negedge clk); rst_n = 1'b1; step();
    chk("R1 up after", up, 1); chk("R1 pulses after", {rise, fall, both}, 0);
  endtask

  task automatic t_polarity();
    lim_hi = 1; step(); lim_hi = 0; chk("R2 hi clears", up, 0);
    lim_hi = 1; lim_lo = 1; step(); chk("R2 both hold low", up, 0);
    lim_hi = 0; step(); chk("R2 lo sets", up, 1);
    lim_hi = 1; step(); chk("R2 both hold high", up, 1);
    lim_hi = 0; lim_lo = 0; step(); chk("R2 idle hold", up, 1);
  endtask

  task automatic t_refsel();
    e_rise = 1; step(); chk("R3 early rise sets", rsel, 1);
    e_fall = 1; step(); chk("R3 both hold", rsel, 1);
    e_rise = 0; step(); chk("R3 early fall clears", rsel, 0);
    e_rise = 1; step(); chk("R3 both hold low", rsel, 0);
    e_rise = 0; e_fall = 0;
  endtask

  task automatic t_slopes();
    // up = 1 here
    zero = 1; step(); chk("R4 rise on", rise, 1); chk("R5 fall off on rising", fall, 0);
    chk("R6 both", both, 1);
    zero = 0; step(); chk("R4 rise off", rise, 0); chk("R5 fall off on rising", fall, 0);
    lim_hi = 1; step(); lim_hi = 0;
    chk("R5 fall on", fall, 1); chk("R4 rise off falling", rise, 0); chk("R6 both", both, 1);
    zero = 1; step(); chk("R5 fall off", fall, 0); chk("R4 rise blocked", rise, 0);
    chk("R6 both low", both, 0);
  endtask

  task automatic t_link();
    // up = 0, zero registered 1 -> both pulses low
    mode = 1; #1; chk("R7 combo low", link, 2'b10);
    zero = 0; step(); chk("R7 combo high", link, 2'b01);
    mode = 0; #1; chk("R7 slopes fall", link, 2'b10);
    lim_lo = 1; zero = 1; step(); lim_lo = 0; chk("R7 slopes rise", link, 2'b01);
    zero = 0; step();
  endtask

  task automatic press();
    btn = 1; repeat (DB + 4) step();
    btn = 0; repeat (DB + 4) step();
  endtask

  task automatic t_range();
    for (int i = 0; i < 4; i++) begin
      press(); exp_idx = (exp_idx + 1) % 3;
      chk("R8 advance/wrap", rng, 3'b001 << exp_idx);
    end
  endtask

  task automatic t_glitch();
    btn = 1; repeat (4) step(); btn = 0; repeat (DB + 4) step();
    chk("R9 short pulse ignored", rng, 3'b001 << exp_idx);
    btn = 1; repeat (DB - 2) step(); btn = 0; repeat (DB + 4) step();
    chk("R9 near-threshold ignored", rng, 3'b001 << exp_idx);
  endtask

  task automatic t_override();
    ext_en = 1; ext_rng = 2; #1; chk("R10 ext idx2", rng, 3'b100);
    ext_rng = 3; #1; chk("R10 ext idx3", rng, 3'b001);
    ext_rng = 1; press(); chk("R10 ext idx1 held", rng, 3'b010);
    exp_idx = (exp_idx + 1) % 3;
    ext_en = 0; #1; chk("R10 internal restored", rng, 3'b001 << exp_idx);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset(); t_polarity(); t_refsel(); t_slopes(); t_link();
        t_range(); t_glitch(); t_override();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule